// File: doc/BRIEF.md
# Hold-Enable Bubble Insertion for a Five-Stage Pipeline

This block holds the three pipeline registers that sit between decode and write-back of a five-stage in-order core (decode-to-execute, execute-to-memory, memory-to-write-back), together with the decode-stage hazard check that inserts a bubble when an instruction consumes the result of the load directly ahead of it. On a hazard it raises stall outputs for fetch and decode for exactly one cycle. The program counter is not updated and the same instruction is presented again on the next cycle.

Each pipeline register is split into two parts. One part holds the write-critical bits: memory write, register-file write, the pending-load marker and the propagated hold flags. This part is loaded every cycle and a bubble clears it. The other part holds the operand data, the destination register number and the non-critical control field, and it has a load enable. When decode inserts a bubble, it creates one enable flag for each downstream register and sends the flags down the pipe with the bubble. Each flag arrives at its register in the cycle the bubble arrives there. That register then keeps the earlier instruction's values, so the datapath behind it does not toggle while the bubble passes.

Top module: `bp_bubble_pipe`

## Requirements
- R1: While rst_n is low, all write-critical bits (idex_mem_we, idex_rf_we, idex_load, exmem_mem_we, exmem_rf_we, memwb_rf_we) are 0, both stall outputs are 0, and every hold flag is set to load normally.
- R2: stall_fetch and stall_decode are 1 in the same cycle in which the decode-to-execute register holds a load (idex_load=1) with a nonzero destination idex_rd that equals dec_rs1 or dec_rs2 or both. Otherwise they are 0.
- R3: A load whose destination is register 0 never causes a stall, whatever the source fields are.
- R4: A bubble lasts one cycle. On the cycle after a stall, the retried instruction does not stall again.
- R5: At the clock edge where a stall is active, idex_mem_we, idex_rf_we and idex_load become 0.
- R6: At that same edge, idex_data, idex_ctrl and idex_rd keep their previous values: zero bit toggles.
- R7: One edge later, exmem_mem_we and exmem_rf_we are 0 and exmem_data, exmem_ctrl and exmem_rd show zero bit toggles.
- R8: Two edges after the stall edge, memwb_rf_we is 0 and memwb_data, memwb_ctrl and memwb_rd show zero bit toggles.
- R9: With no bubble in flight, each register loads every cycle. Decode fields appear on the idex outputs one edge later, on the exmem outputs two edges later and on the memwb outputs three edges later. The write bits follow the same timing.
- R10: The instruction retried after a bubble enters the decode-to-execute register with its own data, control, destination and write bits.
- R11: A load that depends on a load, followed by an instruction that depends on that second load, produces two separate one-cycle bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dec_data | input | DATA_W | Operand and immediate payload of the decode instruction |
| dec_ctrl | input | CTRL_W | Non-critical control field (ALU op, mux selects) |
| dec_rs1 | input | log2(REG_N) | First source register number |
| dec_rs2 | input | log2(REG_N) | Second source register number |
| dec_rd | input | log2(REG_N) | Destination register number |
| dec_load | input | 1 | Decode instruction is a load |
| dec_mem_we | input | 1 | Decode instruction writes memory |
| dec_rf_we | input | 1 | Decode instruction writes the register file |
| stall_fetch | output | 1 | Hold the program counter this cycle |
| stall_decode | output | 1 | Keep the decode instruction for a retry |
| idex_data | output | DATA_W | Decode-to-execute data field |
| idex_ctrl | output | CTRL_W | Decode-to-execute non-critical control |
| idex_rd | output | log2(REG_N) | Decode-to-execute destination |
| idex_load | output | 1 | Decode-to-execute pending-load marker |
| idex_mem_we | output | 1 | Decode-to-execute memory write |
| idex_rf_we | output | 1 | Decode-to-execute register write |
| exmem_data | output | DATA_W | Execute-to-memory data field |
| exmem_ctrl | output | CTRL_W | Execute-to-memory non-critical control |
| exmem_rd | output | log2(REG_N) | Execute-to-memory destination |
| exmem_mem_we | output | 1 | Execute-to-memory memory write |
| exmem_rf_we | output | 1 | Execute-to-memory register write |
| memwb_data | output | DATA_W | Memory-to-write-back data field |
| memwb_ctrl | output | CTRL_W | Memory-to-write-back non-critical control |
| memwb_rd | output | log2(REG_N) | Memory-to-write-back destination |
| memwb_rf_we | output | 1 | Memory-to-write-back register write |

## Verification
The instruction stream covers several cases. A load is read through its first source, its second source, or both. A load targets register 0. A load is followed by an unrelated instruction. A store comes between a load and the instruction that reads it. Two dependent loads run back to back. Together these separate a correct match on the destination from a match on the wrong source or on register 0, and they show whether a second bubble comes from a real dependency or from stale state. For every bubble, the bench counts bit toggles in the held fields of each stage as the bubble passes and expects zero, while the write bits must drop to 0. A stream with no hazards confirms that the hold flags return to normal loading. A reset applied in the middle of the run, with a hazard pending, shows that the critical state is cleared.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Hold flags created in decode and carried down with each instruction.
  // A 1 means the targeted register loads its data part normally.
  typedef struct packed {
    logic ld_memwb;
    logic ld_exmem;
  } bp_hold_flags_t;

  localparam bp_hold_flags_t BP_FLAGS_LOAD = '{ld_memwb: 1'b1, ld_exmem: 1'b1};
  localparam bp_hold_flags_t BP_FLAGS_HOLD = '{ld_memwb: 1'b0, ld_exmem: 1'b0};

  // Critical part of the decode-to-execute register.
  typedef struct packed {
    bp_hold_flags_t flags;
    logic           load;
    logic           rf_we;
    logic           mem_we;
  } bp_idex_crit_t;

  // Critical part of the execute-to-memory register.
  typedef struct packed {
    logic ld_memwb;
    logic rf_we;
    logic mem_we;
  } bp_exmem_crit_t;

endpackage

// File: rtl/bp_hazard.sv
module bp_hazard #(
  parameter int RA_W  = 5,
  parameter int SRC_N = 2
) (
  input  logic                       ex_load,
  input  logic [RA_W-1:0]            ex_rd,
  input  logic [SRC_N-1:0][RA_W-1:0] src,
  output logic                       bubble
);

  logic [SRC_N-1:0] hit;
  logic             rd_live;

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
      assign hit[g] = (src[g] == ex_rd);
    end
  endgenerate

  assign rd_live = (ex_rd != '0);

  always_comb begin
    bubble = ex_load && rd_live && (|hit);
  end

endmodule

// File: rtl/bp_stage_reg.sv
module bp_stage_reg #(
  parameter int               CRIT_W   = 2,
  parameter int               HOLD_W   = 8,
  parameter logic [CRIT_W-1:0] CRIT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRIT_W-1:0] crit_d,
  input  logic              hold_en,
  input  logic [HOLD_W-1:0] hold_d,
  output logic [CRIT_W-1:0] crit_q,
  output logic [HOLD_W-1:0] hold_q
);

  logic [CRIT_W-1:0] crit_n;
  logic [HOLD_W-1:0] hold_n;

  // Next state: critical part every cycle, data part only when enabled.
  always_comb begin
    crit_n = crit_d;
    hold_n = hold_q;
    if (hold_en) begin
      hold_n = hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q <= CRIT_RST;
      hold_q <= '0;
    end else begin
      crit_q <= crit_n;
      hold_q <= hold_n;
    end
  end

  // R6, R7, R8: a deasserted enable freezes the data part across the edge.
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> $stable(hold_q));

endmodule

// File: rtl/bp_bubble_pipe.sv
module bp_bubble_pipe #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int REG_N  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        dec_data,
  input  logic [CTRL_W-1:0]        dec_ctrl,
  input  logic [$clog2(REG_N)-1:0] dec_rs1,
  input  logic [$clog2(REG_N)-1:0] dec_rs2,
  input  logic [$clog2(REG_N)-1:0] dec_rd,
  input  logic                     dec_load,
  input  logic                     dec_mem_we,
  input  logic                     dec_rf_we,
  output logic                     stall_fetch,
  output logic                     stall_decode,
  output logic [DATA_W-1:0]        idex_data,
  output logic [CTRL_W-1:0]        idex_ctrl,
  output logic [$clog2(REG_N)-1:0] idex_rd,
  output logic                     idex_load,
  output logic                     idex_mem_we,
  output logic                     idex_rf_we,
  output logic [DATA_W-1:0]        exmem_data,
  output logic [CTRL_W-1:0]        exmem_ctrl,
  output logic [$clog2(REG_N)-1:0] exmem_rd,
  output logic                     exmem_mem_we,
  output logic                     exmem_rf_we,
  output logic [DATA_W-1:0]        memwb_data,
  output logic [CTRL_W-1:0]        memwb_ctrl,
  output logic [$clog2(REG_N)-1:0] memwb_rd,
  output logic                     memwb_rf_we
);
  import bp_pkg::*;

  localparam int RA_W    = $clog2(REG_N);
  localparam int HOLD_W  = CTRL_W + RA_W + DATA_W;
  localparam int IDEX_CW = $bits(bp_idex_crit_t);
  localparam int EXMEM_CW = $bits(bp_exmem_crit_t);
  localparam bp_idex_crit_t  IDEX_RST  = '{flags: BP_FLAGS_LOAD, load: 1'b0, rf_we: 1'b0, mem_we: 1'b0};
  localparam bp_exmem_crit_t EXMEM_RST = '{ld_memwb: 1'b1, rf_we: 1'b0, mem_we: 1'b0};

  // ---------------- decode: hazard check and bubble formation ----------------
  logic                  bubble;
  logic [1:0][RA_W-1:0]  srcs;
  bp_idex_crit_t         idex_crit_d, idex_crit_q;
  logic [HOLD_W-1:0]     dec_hold, idex_hold;

  assign srcs = {dec_rs2, dec_rs1};

  bp_hazard #(.RA_W(RA_W), .SRC_N(2)) u_hazard (
    .ex_load (idex_crit_q.load),
    .ex_rd   (idex_rd),
    .src     (srcs),
    .bubble  (bubble)
  );

  assign stall_fetch  = bubble;
  assign stall_decode = bubble;
  assign dec_hold     = {dec_ctrl, dec_rd, dec_data};

  always_comb begin
    if (bubble) begin
      idex_crit_d = '{flags: BP_FLAGS_HOLD, load: 1'b0, rf_we: 1'b0, mem_we: 1'b0};
    end else begin
      idex_crit_d = '{flags: BP_FLAGS_LOAD, load: dec_load, rf_we: dec_rf_we, mem_we: dec_mem_we};
    end
  end

  // ---------------- decode-to-execute ----------------
  logic [IDEX_CW-1:0] idex_crit_raw;

  bp_stage_reg #(.CRIT_W(IDEX_CW), .HOLD_W(HOLD_W), .CRIT_RST(IDEX_RST)) u_idex (
    .clk     (clk),
    .rst_n   (rst_n),
    .crit_d  (idex_crit_d),
    .hold_en (!bubble),
    .hold_d  (dec_hold),
    .crit_q  (idex_crit_raw),
    .hold_q  (idex_hold)
  );

  assign idex_crit_q = bp_idex_crit_t'(idex_crit_raw);
  assign {idex_ctrl, idex_rd, idex_data} = idex_hold;
  assign idex_load   = idex_crit_q.load;
  assign idex_mem_we = idex_crit_q.mem_we;
  assign idex_rf_we  = idex_crit_q.rf_we;

  // ---------------- execute-to-memory ----------------
  bp_exmem_crit_t      exmem_crit_d, exmem_crit_q;
  logic [EXMEM_CW-1:0] exmem_crit_raw;
  logic [HOLD_W-1:0]   exmem_hold;

  always_comb begin
    exmem_crit_d = '{ld_memwb: idex_crit_q.flags.ld_memwb,
                     rf_we:    idex_crit_q.rf_we,
                     mem_we:   idex_crit_q.mem_we};
  end

  bp_stage_reg #(.CRIT_W(EXMEM_CW), .HOLD_W(HOLD_W), .CRIT_RST(EXMEM_RST)) u_exmem (
    .clk     (clk),
    .rst_n   (rst_n),
    .crit_d  (exmem_crit_d),
    .hold_en (idex_crit_q.flags.ld_exmem),
    .hold_d  (idex_hold),
    .crit_q  (exmem_crit_raw),
    .hold_q  (exmem_hold)
  );

  assign exmem_crit_q = bp_exmem_crit_t'(exmem_crit_raw);
  assign {exmem_ctrl, exmem_rd, exmem_data} = exmem_hold;
  assign exmem_mem_we = exmem_crit_q.mem_we;
  assign exmem_rf_we  = exmem_crit_q.rf_we;

  // ---------------- memory-to-write-back ----------------
  logic [HOLD_W-1:0] memwb_hold;

  bp_stage_reg #(.CRIT_W(1), .HOLD_W(HOLD_W), .CRIT_RST(1'b0)) u_memwb (
    .clk     (clk),
    .rst_n   (rst_n),
    .crit_d  (exmem_crit_q.rf_we),
    .hold_en (exmem_crit_q.ld_memwb),
    .hold_d  (exmem_hold),
    .crit_q  (memwb_rf_we),
    .hold_q  (memwb_hold)
  );

  assign {memwb_ctrl, memwb_rd, memwb_data} = memwb_hold;

  // ---------------- assertions ----------------
  p_stall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fetch |-> (idex_load && (idex_rd != '0) && ((idex_rd == dec_rs1) || (idex_rd == dec_rs2))));

  p_zero_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rd == '0) |-> !stall_decode);

  p_one_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_decode |=> !stall_decode);

  p_idex_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_decode |=> (!idex_mem_we && !idex_rf_we && !idex_load));

  p_exmem_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_decode |=> ##1 (!exmem_mem_we && !exmem_rf_we && $stable(exmem_data)));

  p_memwb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_decode |=> ##2 (!memwb_rf_we && $stable(memwb_data)));

  p_stall_pair: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fetch == stall_decode);

endmodule

// File: tb/bp_bubble_pipe_tb_top.sv
`timescale 1ns/1ps
module bp_bubble_pipe_tb_top;

  localparam int DW = 32;
  localparam int CW = 8;
  localparam int AW = 5;
  localparam int HW = CW + AW + DW;
  localparam int NV = 16;

  // vector: {exp_stall, load, rs1, rs2, rd, mem_we, rf_we, ctrl, data}
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd1,  5'd2,  5'd3,  1'b0, 1'b1, 8'h11, 32'h1111_0001},
    {1'b0, 1'b1, 5'd3,  5'd0,  5'd5,  1'b0, 1'b1, 8'h22, 32'h2222_0002},
    {1'b1, 1'b0, 5'd5,  5'd6,  5'd4,  1'b0, 1'b1, 8'h33, 32'h3333_0003},
    {1'b0, 1'b1, 5'd4,  5'd0,  5'd0,  1'b0, 1'b1, 8'h44, 32'h4444_0004},
    {1'b0, 1'b0, 5'd0,  5'd0,  5'd6,  1'b0, 1'b1, 8'h55, 32'h5555_0005},
    {1'b0, 1'b1, 5'd2,  5'd0,  5'd7,  1'b0, 1'b1, 8'h66, 32'h6666_0006},
    {1'b1, 1'b0, 5'd1,  5'd7,  5'd8,  1'b0, 1'b1, 8'h77, 32'h7777_0007},
    {1'b0, 1'b1, 5'd8,  5'd0,  5'd9,  1'b0, 1'b1, 8'h88, 32'h8888_0008},
    {1'b1, 1'b1, 5'd9,  5'd0,  5'd10, 1'b0, 1'b1, 8'h99, 32'h9999_0009},
    {1'b1, 1'b0, 5'd1,  5'd10, 5'd0,  1'b1, 1'b0, 8'hAA, 32'hAAAA_000A},
    {1'b0, 1'b0, 5'd10, 5'd10, 5'd11, 1'b0, 1'b1, 8'hBB, 32'hBBBB_000B},
    {1'b0, 1'b1, 5'd1,  5'd0,  5'd12, 1'b0, 1'b1, 8'hCC, 32'hCCCC_000C},
    {1'b1, 1'b0, 5'd12, 5'd12, 5'd13, 1'b0, 1'b1, 8'hDD, 32'hDDDD_000D},
    {1'b0, 1'b1, 5'd1,  5'd0,  5'd14, 1'b0, 1'b1, 8'hEE, 32'hEEEE_000E},
    {1'b0, 1'b0, 5'd1,  5'd2,  5'd15, 1'b0, 1'b1, 8'hFF, 32'hFFFF_000F},
    {1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 8'h00, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [DW-1:0] dec_data;
  logic [CW-1:0] dec_ctrl;
  logic [AW-1:0] dec_rs1, dec_rs2, dec_rd;
  logic dec_load, dec_mem_we, dec_rf_we;
  logic stall_fetch, stall_decode;
  logic [DW-1:0] idex_data, exmem_data, memwb_data;
  logic [CW-1:0] idex_ctrl, exmem_ctrl, memwb_ctrl;
  logic [AW-1:0] idex_rd, exmem_rd, memwb_rd;
  logic idex_load, idex_mem_we, idex_rf_we, exmem_mem_we, exmem_rf_we, memwb_rf_we;

  always #2.5 clk = ~clk;

  bp_bubble_pipe #(.DATA_W(DW), .CTRL_W(CW), .REG_N(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_data(dec_data), .dec_ctrl(dec_ctrl), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .dec_rd(dec_rd), .dec_load(dec_load), .dec_mem_we(dec_mem_we), .dec_rf_we(dec_rf_we),
    .stall_fetch(stall_fetch), .stall_decode(stall_decode),
    .idex_data(idex_data), .idex_ctrl(idex_ctrl), .idex_rd(idex_rd), .idex_load(idex_load),
    .idex_mem_we(idex_mem_we), .idex_rf_we(idex_rf_we),
    .exmem_data(exmem_data), .exmem_ctrl(exmem_ctrl), .exmem_rd(exmem_rd),
    .exmem_mem_we(exmem_mem_we), .exmem_rf_we(exmem_rf_we),
    .memwb_data(memwb_data), .memwb_ctrl(memwb_ctrl), .memwb_rd(memwb_rd),
    .memwb_rf_we(memwb_rf_we)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // reference state built from the requirements
  logic [HW-1:0] m_ie_h, m_em_h, m_mw_h;
  logic m_ie_mw, m_ie_rw, m_ie_ld, m_ie_f1, m_ie_f2;
  logic m_em_mw, m_em_rw, m_em_f2, m_mw_rw;
  bit   b1, b2, b3;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ie_h = '0; m_em_h = '0; m_mw_h = '0;
    m_ie_mw = 0; m_ie_rw = 0; m_ie_ld = 0; m_ie_f1 = 1; m_ie_f2 = 1;
    m_em_mw = 0; m_em_rw = 0; m_em_f2 = 1; m_mw_rw = 0;
    b1 = 0; b2 = 0; b3 = 0;
  endtask

  function automatic logic [HW-1:0] dut_ie();
    return {idex_ctrl, idex_rd, idex_data};
  endfunction
  function automatic logic [HW-1:0] dut_em();
    return {exmem_ctrl, exmem_rd, exmem_data};
  endfunction
  function automatic logic [HW-1:0] dut_mw();
    return {memwb_ctrl, memwb_rd, memwb_data};
  endfunction

  task automatic drive(input logic [58:0] v);
    dec_load   = v[57];
    dec_rs1    = v[56:52];
    dec_rs2    = v[51:47];
    dec_rd     = v[46:42];
    dec_mem_we = v[41];
    dec_rf_we  = v[40];
    dec_ctrl   = v[39:32];
    dec_data   = v[31:0];
  endtask

  // Present one instruction for one cycle; returns the observed stall.
  task automatic step(input logic [58:0] v, input bit first, input string treq, output bit st);
    logic [HW-1:0] p_ie, p_em, p_mw, vh;
    logic [AW-1:0] m_rd;
    bit exp_st;
    drive(v);
    #1;
    m_rd   = m_ie_h[DW +: AW];
    exp_st = m_ie_ld && (m_rd != 0) && ((v[56:52] == m_rd) || (v[51:47] == m_rd));
    st     = stall_decode;
    check(stall_decode == exp_st, first ? treq : "R4", stall_decode, exp_st);
    check(stall_fetch == exp_st, first ? treq : "R4", stall_fetch, exp_st);
    if (first) check(exp_st == v[58], "table", exp_st, v[58]);
    p_ie = dut_ie(); p_em = dut_em(); p_mw = dut_mw();
    vh = {v[39:32], v[46:42], v[31:0]};
    // advance the model
    m_mw_rw = m_em_rw;
    if (m_em_f2) m_mw_h = m_em_h;
    m_em_mw = m_ie_mw; m_em_rw = m_ie_rw; m_em_f2 = m_ie_f2;
    if (m_ie_f1) m_em_h = m_ie_h;
    if (exp_st) begin
      m_ie_mw = 0; m_ie_rw = 0; m_ie_ld = 0; m_ie_f1 = 0; m_ie_f2 = 0;
    end else begin
      m_ie_mw = v[41]; m_ie_rw = v[40]; m_ie_ld = v[57]; m_ie_f1 = 1; m_ie_f2 = 1;
      m_ie_h = vh;
    end
    b3 = b2; b2 = b1; b1 = exp_st;
    @(negedge clk);
    // R9: per-stage contents match the expected flow
    check(dut_ie() == m_ie_h, "R9 idex fields", dut_ie(), m_ie_h);
    check(dut_em() == m_em_h, "R9 exmem fields", dut_em(), m_em_h);
    check(dut_mw() == m_mw_h, "R9 memwb fields", dut_mw(), m_mw_h);
    check({idex_mem_we, idex_rf_we, idex_load} == {m_ie_mw, m_ie_rw, m_ie_ld}, "R9 idex writes",
          {idex_mem_we, idex_rf_we, idex_load}, {m_ie_mw, m_ie_rw, m_ie_ld});
    check({exmem_mem_we, exmem_rf_we, memwb_rf_we} == {m_em_mw, m_em_rw, m_mw_rw}, "R9 late writes",
          {exmem_mem_we, exmem_rf_we, memwb_rf_we}, {m_em_mw, m_em_rw, m_mw_rw});
    if (b1) begin
      check({idex_mem_we, idex_rf_we, idex_load} == 3'b000, "R5", {idex_mem_we, idex_rf_we, idex_load}, 0);
      check($countones(p_ie ^ dut_ie()) == 0, "R6 toggles", $countones(p_ie ^ dut_ie()), 0);
    end
    if (b2) begin
      check({exmem_mem_we, exmem_rf_we} == 2'b00, "R7 writes", {exmem_mem_we, exmem_rf_we}, 0);
      check($countones(p_em ^ dut_em()) == 0, "R7 toggles", $countones(p_em ^ dut_em()), 0);
    end
    if (b3) begin
      check(memwb_rf_we == 1'b0, "R8 write", memwb_rf_we, 0);
      check($countones(p_mw ^ dut_mw()) == 0, "R8 toggles", $countones(p_mw ^ dut_mw()), 0);
    end
    if (!first && !exp_st) begin
      check(dut_ie() == vh, "R10 retried fields", dut_ie(), vh);
      check({idex_mem_we, idex_rf_we, idex_load} == {v[41], v[40], v[57]}, "R10 retried writes",
            {idex_mem_we, idex_rf_we, idex_load}, {v[41], v[40], v[57]});
    end
  endtask

  task automatic check_reset_state(input string tag);
    check({idex_mem_we, idex_rf_we, idex_load, exmem_mem_we, exmem_rf_we, memwb_rf_we} == 6'b0,
          tag, {idex_mem_we, idex_rf_we, idex_load, exmem_mem_we, exmem_rf_we, memwb_rf_we}, 0);
    check({stall_fetch, stall_decode} == 2'b00, tag, {stall_fetch, stall_decode}, 0);
  endtask

  initial begin
    bit st;
    rst_n = 1'b0;
    drive('0);
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;

    // table walk: each instruction is retried while a stall is reported
    for (int i = 0; i < NV; i++) begin
      string tr;
      tr = (i == 4) ? "R3" : ((i == 8 || i == 9) ? "R11" : "R2");
      step(VEC[i], 1'b1, tr, st);
      while (st) step(VEC[i], 1'b0, tr, st);
    end
    // drain so every bubble and instruction reaches write-back
    for (int k = 0; k < 3; k++) step(VEC[NV-1], 1'b1, "R9", st);

    // directed: reset in the middle of a pending hazard (R1)
    step({1'b0, 1'b1, 5'd1, 5'd0, 5'd3, 1'b0, 1'b1, 8'h5A, 32'h0BAD_F00D}, 1'b1, "R2", st);
    drive({1'b1, 1'b0, 5'd3, 5'd0, 5'd4, 1'b1, 1'b1, 8'hA5, 32'h1234_5678});
    #1;
    check(stall_decode == 1'b1, "R2 directed", stall_decode, 1);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1 mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // after reset the flags load normally: a plain instruction flows through
    step({1'b0, 1'b0, 5'd3, 5'd0, 5'd4, 1'b1, 1'b1, 8'hA5, 32'h1234_5678}, 1'b1, "R1 flags", st);
    for (int k = 0; k < 3; k++) step(VEC[NV-1], 1'b1, "R9", st);
    check(memwb_data == 32'h0000_0000 && exmem_data == 32'h0000_0000, "R9 drain", memwb_data, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule